// File: doc/BRIEF.md
# Kernel Segment Address Translator

This block is the first stage of address translation. For each access it takes the virtual address, the privilege mode, the access type and four configuration words. From these it produces either a final physical address with full permissions, or a request handed on to a separate page-lookup block. The page-lookup block is not part of this design.

There are three outcomes. When translation is switched off, the address passes through unchanged. When a kernel-mode access lands in a 256 MB region whose direct-map enable is set, the top four address bits are replaced by a nibble taken from one of two kernel-base words. Every other access becomes a request to the page path. Exec accesses are steered to the instruction side and everything else to the data side. The page path's answer is handed back to the requester unchanged.

The whole block is combinational. A request/ready pair and a response-valid pass straight through between the requester and the page path.

Top module: `segxl_top`

## Requirements
- R1: Translation is on exactly when `gcCfg[3:2]` is nonzero. The other bits of `gcCfg` have no effect.
- R2: With translation off, `physAddr` equals `vaddr`, `perm` is 3'b111 (bit 0 read, bit 1 write, bit 2 exec), `miss` is 0, `respValid` follows `reqValid`, `reqReady` is 1 and `pageReqValid` is 0.
- R3: The region number is `vaddr[31:28]`. A region is direct-mapped when `userMode` is 0 and bit [region] of `mmCfg` is 1.
- R4: Region r in 0..7 takes its nibble from `kbaseLo[4*r+3:4*r]`. Region r in 8..15 takes it from `kbaseHi[4*(r-8)+3:4*(r-8)]`.
- R5: A direct-mapped access gives `physAddr = {nibble, vaddr[27:0]}`, `perm` = 3'b111 and `miss` = 0. `respValid` follows `reqValid`, `reqReady` is 1 and no page request is raised.
- R6: A user-mode access is never direct-mapped. With translation on, it always goes to the page path, whatever the `mmCfg` bits are.
- R7: A page-path access drives `pageReqValid = reqValid` and `reqReady = pageReqReady`. `pageReqSide` is 1 (instruction side) when `accType` is 2 (exec) and 0 (data side) otherwise. Access type codes: 0 read, 1 write, 2 exec.
- R8: For a page-path access, `respValid`, `physAddr`, `perm` and `miss` equal `pageRespValid`, `pagePhys`, `pagePerm` and `pageMiss`.
- R9: Access type code 3 is handled as a read, so it goes to the data side.
- R10: Bits 31:16 of `mmCfg` never direct-map any region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Access accepted |
| vaddr | input | 32 | Virtual address |
| userMode | input | 1 | 1 = user mode, 0 = kernel mode |
| accType | input | 2 | 0 read, 1 write, 2 exec, 3 read |
| gcCfg | input | 32 | Global config; bits 3:2 enable translation |
| mmCfg | input | 32 | Per-region direct-map enables in bits 15:0 |
| kbaseLo | input | 32 | Base nibbles for regions 0..7 |
| kbaseHi | input | 32 | Base nibbles for regions 8..15 |
| pageReqValid | output | 1 | Request toward the page path |
| pageReqSide | output | 1 | 1 = instruction side, 0 = data side |
| pageReqReady | input | 1 | Page path accepts request |
| pageRespValid | input | 1 | Page path result valid |
| pagePhys | input | 32 | Page path physical address |
| pagePerm | input | 3 | Page path permissions |
| pageMiss | input | 1 | Page path miss |
| respValid | output | 1 | Result valid |
| physAddr | output | 32 | Physical address |
| perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 exec |
| miss | output | 1 | Translation miss |

## Verification
Every output depends only on the present inputs, so each result is due in the same cycle as its stimulus, with no register in between. The bench applies inputs just after a rising edge and samples all outputs at the following falling edge, half a period later, once the logic has settled. Page-path results and handshakes are driven in the same cycle as the request, so forwarded values are checked in that same window.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  localparam int ADDR_W = 32;
  localparam int SEG_W  = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  localparam logic [2:0] PERM_ALL = 3'b111;

  typedef struct packed {
    logic useSeg;   // region direct-map result
    logic usePage;  // hand off to page path
  } strb_t;
endpackage

// File: rtl/segxl_ctrl.sv
module segxl_ctrl
  import segxl_pkg::*;
#(
  parameter int SEG_BITS = SEG_W,
  parameter int CFG_W    = 32
) (
  input  logic [SEG_BITS-1:0] segNum,
  input  logic                userMode,
  input  logic [1:0]          accType,
  input  logic [CFG_W-1:0]    gcCfg,
  input  logic [CFG_W-1:0]    mmCfg,
  input  logic                reqValid,
  input  logic                pageReqReady,
  output strb_t               strb,
  output logic                pageReqValid,
  output logic                pageReqSide,
  output logic                reqReady
);
  localparam int NSEG = 1 << SEG_BITS;

  logic mmuOn;
  logic segHit;
  logic [NSEG-1:0] segEn;

  assign segEn  = mmCfg[NSEG-1:0];
  assign mmuOn  = |gcCfg[3:2];
  assign segHit = !userMode && segEn[segNum];

  always_comb begin
    strb.useSeg  = mmuOn && segHit;
    strb.usePage = mmuOn && !segHit;
    pageReqValid = strb.usePage && reqValid;
    pageReqSide  = (accType == ACC_EXEC);
    reqReady     = strb.usePage ? pageReqReady : 1'b1;
  end
endmodule

// File: rtl/segxl_datapath.sv
module segxl_datapath
  import segxl_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int SEG_BITS = SEG_W
) (
  input  logic [AW-1:0]                        vaddr,
  input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0] kbaseLo,
  input  logic [((1<<SEG_BITS)/2)*SEG_BITS-1:0] kbaseHi,
  input  strb_t                                strb,
  input  logic                                 reqValid,
  input  logic                                 pageRespValid,
  input  logic [AW-1:0]                        pagePhys,
  input  logic [2:0]                           pagePerm,
  input  logic                                 pageMiss,
  output logic                                 respValid,
  output logic [AW-1:0]                        physAddr,
  output logic [2:0]                           perm,
  output logic                                 miss
);
  localparam int NSEG  = 1 << SEG_BITS;
  localparam int HALF  = NSEG / 2;
  localparam int OFF_W = AW - SEG_BITS;

  logic [SEG_BITS-1:0] nibTab [NSEG];
  logic [SEG_BITS-1:0] segNum;
  logic [AW-1:0]       mappedAddr;

  for (genvar g = 0; g < NSEG; g++) begin : g_nib
    if (g < HALF) begin : g_lo
      assign nibTab[g] = kbaseLo[g*SEG_BITS +: SEG_BITS];
    end else begin : g_hi
      assign nibTab[g] = kbaseHi[(g-HALF)*SEG_BITS +: SEG_BITS];
    end
  end

  assign segNum     = vaddr[AW-1 -: SEG_BITS];
  assign mappedAddr = {nibTab[segNum], vaddr[OFF_W-1:0]};

  always_comb begin
    if (strb.usePage) begin
      respValid = pageRespValid;
      physAddr  = pagePhys;
      perm      = pagePerm;
      miss      = pageMiss;
    end else begin
      respValid = reqValid;
      physAddr  = strb.useSeg ? mappedAddr : vaddr;
      perm      = PERM_ALL;
      miss      = 1'b0;
    end
  end
endmodule

// File: rtl/segxl_top.sv
module segxl_top
  import segxl_pkg::*;
(
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] vaddr,
  input  logic        userMode,
  input  logic [1:0]  accType,
  input  logic [31:0] gcCfg,
  input  logic [31:0] mmCfg,
  input  logic [31:0] kbaseLo,
  input  logic [31:0] kbaseHi,
  output logic        pageReqValid,
  output logic        pageReqSide,
  input  logic        pageReqReady,
  input  logic        pageRespValid,
  input  logic [31:0] pagePhys,
  input  logic [2:0]  pagePerm,
  input  logic        pageMiss,
  output logic        respValid,
  output logic [31:0] physAddr,
  output logic [2:0]  perm,
  output logic        miss
);
  strb_t strb;

  segxl_ctrl #(.SEG_BITS(SEG_W), .CFG_W(32)) u_ctrl (
    .segNum      (vaddr[31:28]),
    .userMode    (userMode),
    .accType     (accType),
    .gcCfg       (gcCfg),
    .mmCfg       (mmCfg),
    .reqValid    (reqValid),
    .pageReqReady(pageReqReady),
    .strb        (strb),
    .pageReqValid(pageReqValid),
    .pageReqSide (pageReqSide),
    .reqReady    (reqReady)
  );

  segxl_datapath #(.AW(ADDR_W), .SEG_BITS(SEG_W)) u_dp (
    .vaddr        (vaddr),
    .kbaseLo      (kbaseLo),
    .kbaseHi      (kbaseHi),
    .strb         (strb),
    .reqValid     (reqValid),
    .pageRespValid(pageRespValid),
    .pagePhys     (pagePhys),
    .pagePerm     (pagePerm),
    .pageMiss     (pageMiss),
    .respValid    (respValid),
    .physAddr     (physAddr),
    .perm         (perm),
    .miss         (miss)
  );
endmodule

// File: rtl/segxl_checker.sv
module segxl_checker (
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] vaddr,
  input logic        userMode,
  input logic [1:0]  accType,
  input logic [31:0] gcCfg,
  input logic [31:0] mmCfg,
  input logic        pageReqValid,
  input logic        pageReqSide,
  input logic        pageRespValid,
  input logic [31:0] pagePhys,
  input logic        respValid,
  input logic [31:0] physAddr,
  input logic [2:0]  perm,
  input logic        miss
);
  logic known;
  assign known = !$isunknown({reqValid, vaddr, userMode, accType, gcCfg, mmCfg,
                              pageRespValid, pagePhys});

  always_comb begin
    if (known) begin
      if (gcCfg[3:2] == 2'b00) begin
        p_bypass_r2: assert (physAddr == vaddr && perm == 3'b111 && !miss && !pageReqValid)
          else $error("bypass mismatch");
      end
      if (gcCfg[3:2] != 2'b00 && !userMode && mmCfg[vaddr[31:28]]) begin
        p_segmap_r5: assert (physAddr[27:0] == vaddr[27:0] && perm == 3'b111 && !miss
                             && !pageReqValid && respValid == reqValid)
          else $error("segment map mismatch");
      end
      if (gcCfg[3:2] != 2'b00 && userMode) begin
        p_user_page_r6: assert (physAddr == pagePhys && respValid == pageRespValid)
          else $error("user access not on page path");
      end
      if (pageReqValid) begin
        p_side_r7: assert (reqValid && pageReqSide == (accType == 2'd2))
          else $error("page request side or valid wrong");
      end
    end
  end
endmodule

bind segxl_top segxl_checker u_chk (
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .vaddr        (vaddr),
  .userMode     (userMode),
  .accType      (accType),
  .gcCfg        (gcCfg),
  .mmCfg        (mmCfg),
  .pageReqValid (pageReqValid),
  .pageReqSide  (pageReqSide),
  .pageRespValid(pageRespValid),
  .pagePhys     (pagePhys),
  .respValid    (respValid),
  .physAddr     (physAddr),
  .perm         (perm),
  .miss         (miss)
);

// File: tb/segxl_top_bench.sv
`timescale 1ns/1ps
module segxl_top_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        reqValid = 0, userMode = 0, pageReqReady = 0, pageRespValid = 0, pageMiss = 0;
  logic [1:0]  accType = 0;
  logic [31:0] vaddr = 0, gcCfg = 0, mmCfg = 0, kbaseLo = 0, kbaseHi = 0, pagePhys = 0;
  logic [2:0]  pagePerm = 0;
  logic        reqReady, pageReqValid, pageReqSide, respValid, miss;
  logic [31:0] physAddr;
  logic [2:0]  perm;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  segxl_top u_segxl_top (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected nibble for a region, from the requirement text.
  function automatic logic [3:0] expNib(logic [3:0] s, logic [31:0] lo, logic [31:0] hi);
    logic [31:0] w = (s < 8) ? lo : hi;
    return w[(s % 8) * 4 +: 4];
  endfunction

  // Apply stimulus after a rising edge, check at the falling edge.
  task automatic apply_and_check(string tag);
    logic on, seg, pg;
    logic [31:0] eAddr;
    logic [2:0]  ePerm;
    logic        eMiss, eResp, eReady, eReq;
    @(negedge clk);
    on  = (gcCfg[3:2] != 0);
    seg = on && !userMode && (mmCfg[15:0] >> vaddr[31:28]) & 1'b1;
    pg  = on && !seg;
    if (pg) begin
      eAddr = pagePhys; ePerm = pagePerm; eMiss = pageMiss; eResp = pageRespValid;
      eReady = pageReqReady; eReq = reqValid;
    end else begin
      eAddr = seg ? {expNib(vaddr[31:28], kbaseLo, kbaseHi), vaddr[27:0]} : vaddr;
      ePerm = 3'b111; eMiss = 0; eResp = reqValid; eReady = 1; eReq = 0;
    end
    chk({tag, " addr"}, {32'd0, physAddr}, {32'd0, eAddr});
    chk({tag, " ctl"}, {57'd0, perm, miss, respValid, reqReady, pageReqValid},
                       {57'd0, ePerm, eMiss, eResp, eReady, eReq});
    if (pg && reqValid)
      chk({tag, " side R7"}, {63'd0, pageReqSide}, {63'd0, accType == 2'd2});
    @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);

    // R2 reset/bypass state: translation off
    vaddr = 32'hDEAD_BEEF; reqValid = 1; gcCfg = 32'hFFFF_FFF3; mmCfg = 32'hFFFF;
    apply_and_check("R2 bypass");
    // R1: only bits 3:2 enable; bits 1:0 and 4+ set does not
    gcCfg = 32'h0000_0013; apply_and_check("R1 other bits");
    gcCfg = 32'h0000_0004; kbaseLo = 32'h7654_3210; kbaseHi = 32'hFEDC_BA98;
    apply_and_check("R1 enabled bit2");
    // R4 boundaries: region 7 and 8
    mmCfg = 32'h0000_0180; vaddr = 32'h7123_4567; apply_and_check("R4 region7");
    vaddr = 32'h8ABC_DEF0; apply_and_check("R4 region8");
    // R10: high mmCfg bits do not map
    gcCfg = 32'h8; mmCfg = 32'hFFFF_0000; vaddr = 32'h3000_0010;
    pagePhys = 32'h1111_2222; pagePerm = 3'b010; pageMiss = 1; pageRespValid = 1; pageReqReady = 0;
    apply_and_check("R10 high cfg");
    // R9: type 3 goes to data side
    accType = 2'd3; apply_and_check("R9 type3");
    chk("R9 side", {63'd0, pageReqSide}, 64'd0);
    // R7 exec side and handshake
    accType = 2'd2; pageReqReady = 1; apply_and_check("R7 exec");
    // R6: user mode with all enables set
    userMode = 1; mmCfg = 32'hFFFF; apply_and_check("R6 user");
    // R8: page forwarding with no request pending
    reqValid = 0; pageRespValid = 0; apply_and_check("R8 idle");

    // R3 R5 R6 R8 random sweep of all regions in both modes
    for (int s = 0; s < 16; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 4; k++) begin
          kbaseLo = $urandom; kbaseHi = $urandom;
          mmCfg = $urandom; mmCfg[s] = k[0];
          gcCfg = $urandom; if (k != 3) gcCfg[3:2] = 2'(1 + (k % 3));
          vaddr = {4'(s), 28'($urandom)};
          userMode = m[0]; accType = 2'($urandom);
          reqValid = 1'($urandom); pageReqReady = 1'($urandom);
          pageRespValid = 1'($urandom); pagePhys = $urandom;
          pagePerm = 3'($urandom); pageMiss = 1'($urandom);
          apply_and_check("R3 R5 R6 R8 sweep");
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule